// File: doc/BRIEF.md
# Plug and Play Initiation Key Detector

This block keeps a card's auto-configuration ports closed until the host has written a fixed 32-byte unlock sequence to the configuration address port. It watches every host I/O write. A write counts only when the full address matches the port and the extra high decode bits are zero. Each counted byte is compared with the byte the sequence expects next.

The expected bytes are not stored in a table. A small byte-wide shift register produces them one step at a time. Its seed is 6Ah. Each step shifts the byte right by one place and fills the top bit with the exclusive-or of the two lowest bits.

A wrong byte abandons the attempt. If that wrong byte happens to equal the first key byte, it opens a new attempt at once. When the last byte matches, the block pulses a detect output for one clock and raises a sticky enable flag for the card state logic. The enable flag stays up until reset.

Top module: `pnp_key_detect`

## Requirements
- R1: While the synchronous reset is high, and on the first clock after it falls, both `key_found_o` and `pnp_en_o` read 0, and any earlier match progress is discarded.
- R2: A write takes part in matching only when `wr_en_i` is 1 and `addr_i` equals 12'h279 in all twelve bits. Addresses 12'hA79 (bit 11 set) and 12'h679 (bit 10 set) are not the port.
- R3: The key is 32 bytes long and its first byte is 8'h6A. Each next byte is the current byte shifted right by one, with bit 7 set to bit1 XOR bit0 of the current byte, so the key begins 6A, B5, DA, ED.
- R4: The clock edge that accepts the 32nd consecutive matching byte sets `key_found_o` to 1. It stays 1 for exactly one cycle.
- R5: `pnp_en_o` rises together with the first detect pulse and then stays 1 until reset.
- R6: A counted write whose byte differs from the expected byte discards all progress. The key must then be sent again from its first byte.
- R7: A mismatching counted byte that equals 8'h6A is taken as the first byte of a new attempt. The next expected byte is then B5.
- R8: Cycles without a counted write do not change the match progress. This covers idle cycles, writes to other addresses, and bus activity with `wr_en_i` low.
- R9: After a detection, matching restarts from the first key byte. A second complete key produces a second pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| addr_i | input | 12 | Host I/O address, including the high decode bits |
| wr_en_i | input | 1 | One-cycle host write strobe |
| data_i | input | 8 | Host write data byte |
| key_found_o | output | 1 | One-cycle pulse when the full key has been matched |
| pnp_en_o | output | 1 | Sticky flag: auto-configuration ports enabled |

## Verification
A wrong internal position or a wrong sequence byte shows up at the ports in one of three ways:

- The detect pulse is missing after a correct key.
- The detect pulse comes early, after a wrong byte, or after a write to an aliased address.
- `pnp_en_o` rises or falls at the wrong time.

A behavioural model in the bench tracks the key position with an integer and a precomputed byte list. It compares both outputs on every clock, so any divergence is reported on the cycle after the write that exposes it. Scenarios include interrupted keys, mismatches equal to the first key byte, interleaved foreign writes, back-to-back keys, and reset in the middle of a key. Together they make a corrupted counter or shift register visible within at most one key length.

// File: rtl/pnp_key_pkg.sv
package pnp_key_pkg;

    localparam int KEY_LEN   = 32;
    localparam int BYTE_W    = 8;
    localparam int CNT_W     = $clog2(KEY_LEN);
    localparam logic [BYTE_W-1:0] KEY_SEED = 8'h6A;
    localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(KEY_LEN - 1);

    typedef logic [BYTE_W-1:0] key_byte_t;
    typedef logic [CNT_W-1:0]  key_cnt_t;

    // One host bus cycle as seen after address decode
    typedef struct packed {
        logic      hit;
        key_byte_t data;
    } wr_ev_t;

    // What a cycle does to the matching progress
    typedef enum logic [2:0] {
        ACT_IDLE    = 3'd0,
        ACT_ADVANCE = 3'd1,
        ACT_DONE    = 3'd2,
        ACT_RESTART = 3'd3,
        ACT_REARM   = 3'd4
    } match_act_t;

    // Right shift, new msb = xor of the two lowest bits
    function automatic key_byte_t key_step(input key_byte_t cur);
        key_byte_t nxt;
        nxt = {1'b0, cur[BYTE_W-1:1]};
        nxt[BYTE_W-1] = cur[1] ^ cur[0];
        return nxt;
    endfunction

endpackage

// File: rtl/pnp_port_decode.sv
module pnp_port_decode
    import pnp_key_pkg::*;
#(
    parameter int              ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 12'h279
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  key_byte_t         data_i,
    output wr_ev_t            ev_o
);

    logic [ADDR_W-1:0] bit_ok;

    // Full decode: every address bit must agree, including high bits
    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        assign bit_ok[i] = ~(addr_i[i] ^ PORT_ADDR[i]);
    end

    always_comb begin
        ev_o.hit  = wr_en_i & (&bit_ok);
        ev_o.data = data_i;
    end

endmodule

// File: rtl/pnp_key_tracker.sv
module pnp_key_tracker
    import pnp_key_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  wr_ev_t     ev_i,
    input  key_byte_t  exp_i,
    output match_act_t act_o,
    output key_cnt_t   cnt_o
);

    key_cnt_t cnt_q;
    key_cnt_t cnt_d;

    always_comb begin
        if (!ev_i.hit) begin
            act_o = ACT_IDLE;
        end else if (ev_i.data == exp_i) begin
            act_o = (cnt_q == CNT_LAST) ? ACT_DONE : ACT_ADVANCE;
        end else if (ev_i.data == KEY_SEED) begin
            act_o = ACT_REARM;
        end else begin
            act_o = ACT_RESTART;
        end
    end

    always_comb begin
        unique case (act_o)
            ACT_ADVANCE: cnt_d = cnt_q + 1'b1;
            ACT_DONE:    cnt_d = '0;
            ACT_REARM:   cnt_d = key_cnt_t'(1);
            ACT_RESTART: cnt_d = '0;
            default:     cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) cnt_q <= '0;
        else       cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/pnp_key_lfsr.sv
module pnp_key_lfsr
    import pnp_key_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  match_act_t act_i,
    output key_byte_t  exp_o
);

    key_byte_t exp_q;
    key_byte_t exp_d;

    always_comb begin
        unique case (act_i)
            ACT_ADVANCE: exp_d = key_step(exp_q);
            ACT_DONE:    exp_d = KEY_SEED;
            ACT_REARM:   exp_d = key_step(KEY_SEED);
            ACT_RESTART: exp_d = KEY_SEED;
            default:     exp_d = exp_q;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) exp_q <= KEY_SEED;
        else       exp_q <= exp_d;
    end

    assign exp_o = exp_q;

endmodule

// File: rtl/pnp_key_detect.sv
module pnp_key_detect
    import pnp_key_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 12'h279
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [7:0]        data_i,
    output logic              key_found_o,
    output logic              pnp_en_o
);

    wr_ev_t     ev;
    key_byte_t  exp_byte;
    match_act_t act;
    key_cnt_t   match_cnt;
    logic       found_q;
    logic       en_q;

    pnp_port_decode #(
        .ADDR_W    (ADDR_W),
        .PORT_ADDR (PORT_ADDR)
    ) u_decode (
        .addr_i  (addr_i),
        .wr_en_i (wr_en_i),
        .data_i  (data_i),
        .ev_o    (ev)
    );

    pnp_key_tracker u_tracker (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .ev_i  (ev),
        .exp_i (exp_byte),
        .act_o (act),
        .cnt_o (match_cnt)
    );

    pnp_key_lfsr u_lfsr (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .act_i (act),
        .exp_o (exp_byte)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            found_q <= 1'b0;
            en_q    <= 1'b0;
        end else begin
            found_q <= (act == ACT_DONE);
            en_q    <= en_q | (act == ACT_DONE);
        end
    end

    assign key_found_o = found_q;
    assign pnp_en_o    = en_q;

endmodule

// File: rtl/pnp_key_detect_chk.sv
module pnp_key_detect_chk
    import pnp_key_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 12'h279
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              wr_en_i,
    input logic              key_found_o,
    input logic              pnp_en_o,
    input key_cnt_t          match_cnt
);

    // R1
    reset_clears_chk: assert property (@(posedge clk_i)
        rst_i |=> (!key_found_o && !pnp_en_o));

    // R2
    pulse_needs_port_write_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !(wr_en_i && addr_i == PORT_ADDR) |=> !key_found_o);

    // R4
    single_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        key_found_o |=> !key_found_o);

    // R5
    pulse_enables_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        key_found_o |-> pnp_en_o);

    // R5
    enable_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(pnp_en_o) |-> $past(rst_i));

    // R8
    idle_keeps_progress_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !(wr_en_i && addr_i == PORT_ADDR) |=> $stable(match_cnt));

endmodule

bind pnp_key_detect pnp_key_detect_chk #(
    .ADDR_W    (ADDR_W),
    .PORT_ADDR (PORT_ADDR)
) chk_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .addr_i      (addr_i),
    .wr_en_i     (wr_en_i),
    .key_found_o (key_found_o),
    .pnp_en_o    (pnp_en_o),
    .match_cnt   (match_cnt)
);

// File: tb/pnp_key_detect_tb_top.sv
`timescale 1ns/1ps
module pnp_key_detect_tb_top;

    localparam logic [11:0] PORT  = 12'h279;
    localparam int          KLEN  = 32;

    logic        clk_i = 1'b0;
    logic        rst_i = 1'b1;
    logic [11:0] addr_i = '0;
    logic        wr_en_i = 1'b0;
    logic [7:0]  data_i = '0;
    logic        key_found_o;
    logic        pnp_en_o;

    int checks = 0;
    int errors = 0;
    int key_tbl [KLEN];
    int m_pos = 0;
    bit m_pulse = 0;
    bit m_en = 0;
    int pulses_seen = 0;
    string cur_req = "R1";
    bit done = 0;

    always #2.5 clk_i = ~clk_i;

    pnp_key_detect dut_i (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .addr_i      (addr_i),
        .wr_en_i     (wr_en_i),
        .data_i      (data_i),
        .key_found_o (key_found_o),
        .pnp_en_o    (pnp_en_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drive one cycle (called at a negedge), advance model, compare after edge
    task automatic cyc(input bit rst, input bit w, input logic [11:0] a, input int d);
        rst_i = rst; wr_en_i = w; addr_i = a; data_i = 8'(d);
        if (rst) begin
            m_pos = 0; m_en = 0; m_pulse = 0;
        end else begin
            m_pulse = 0;
            if (w && a == PORT) begin
                if (d == key_tbl[m_pos]) begin
                    if (m_pos == KLEN - 1) begin
                        m_pulse = 1; m_en = 1; m_pos = 0;
                    end else begin
                        m_pos = m_pos + 1;
                    end
                end else if (d == key_tbl[0]) begin
                    m_pos = 1;
                end else begin
                    m_pos = 0;
                end
            end
        end
        @(negedge clk_i);
        chk(key_found_o == m_pulse, cur_req, key_found_o, m_pulse, "key_found_o");
        chk(pnp_en_o == m_en, cur_req, pnp_en_o, m_en, "pnp_en_o");
        if (key_found_o) pulses_seen++;
    endtask

    task automatic send_key(input int from, input int upto);
        for (int i = from; i <= upto; i++) cyc(0, 1, PORT, key_tbl[i]);
    endtask

    task automatic expect_pulses(input int n, input string req);
        chk(pulses_seen == n, req, pulses_seen, n, "pulse count");
        pulses_seen = 0;
    endtask

    initial begin
        int b;
        b = 'h6A;
        for (int i = 0; i < KLEN; i++) begin
            key_tbl[i] = b;
            b = (b >> 1) | (((b ^ (b >> 1)) & 1) << 7);
        end

        @(negedge clk_i);
        cur_req = "R1";
        for (int i = 0; i < 3; i++) cyc(1, 0, '0, 0);
        cyc(0, 0, '0, 0);

        // R3: first bytes of the sequence
        chk(key_tbl[1] == 'hB5 && key_tbl[2] == 'hDA && key_tbl[3] == 'hED, "R3",
            key_tbl[3], 'hED, "key table");
        cur_req = "R3";
        send_key(0, KLEN - 1);
        expect_pulses(1, "R4");
        cur_req = "R5";
        for (int i = 0; i < 5; i++) cyc(0, 0, PORT, 0);
        chk(pnp_en_o == 1'b1, "R5", pnp_en_o, 1, "sticky enable");

        // R6: wrong byte in the middle
        cur_req = "R6";
        send_key(0, 9);
        cyc(0, 1, PORT, 'h00);
        send_key(10, KLEN - 1);
        expect_pulses(0, "R6");
        send_key(0, KLEN - 1);
        expect_pulses(1, "R6");

        // R7: mismatching seed starts a new attempt
        cur_req = "R7";
        send_key(0, 4);
        cyc(0, 1, PORT, 'h6A);
        send_key(1, KLEN - 1);
        expect_pulses(1, "R7");

        // R2 and R8: foreign writes, aliased addresses, no strobe
        cur_req = "R8";
        for (int i = 0; i < KLEN; i++) begin
            cyc(0, 1, PORT, key_tbl[i]);
            cyc(0, 1, 12'hA79, 'h00);
            cyc(0, 1, 12'h679, 'h11);
            cyc(0, 0, PORT, 'h22);
            cyc(0, 1, 12'h278, 'h33);
        end
        expect_pulses(1, "R8");
        cur_req = "R2";
        for (int i = 0; i < KLEN; i++) cyc(0, 1, 12'hA79, key_tbl[i]);
        expect_pulses(0, "R2");
        for (int i = 0; i < KLEN; i++) cyc(0, 1, 12'h679, key_tbl[i]);
        expect_pulses(0, "R2");

        // R9: back-to-back keys
        cur_req = "R9";
        send_key(0, KLEN - 1);
        send_key(0, KLEN - 1);
        expect_pulses(2, "R9");

        // R1: reset mid-key discards progress and the enable
        cur_req = "R1";
        send_key(0, 15);
        cyc(1, 0, '0, 0);
        chk(pnp_en_o == 1'b0, "R1", pnp_en_o, 0, "enable after reset");
        send_key(16, KLEN - 1);
        expect_pulses(0, "R1");
        send_key(0, KLEN - 1);
        expect_pulses(1, "R1");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk_i);
        if (!done) begin
            errors++;
            $display("FAIL R4 watchdog: actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule